// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit operands and a carry-in and produces the 16-bit sum and the carry-out, with no storage. The operand width is split into groups of four bits. Each bit forms a generate term (both inputs high) and a propagate term (inputs differ). Each group forms all of its internal carries at once from those terms and its own carry-in, and reports a group generate and a group propagate. A second lookahead stage takes the four group pairs and the carry-in and forms the carry into every group at once, so no carry passes from one group to the next through a chain.

The block also reports a block-wide generate and propagate, which lets a wider adder use it as one group of a third lookahead level. Group size and group count are parameters; the defaults give 16 bits as four groups of four.

Top module: `cla_hier_adder`

## Requirements
- R1: `sum_o` equals the low 16 bits of `a_i + b_i + cin_i`, with all three read as unsigned, in the same cycle the inputs are applied.
- R2: `cout_o` equals bit 16 of the unsigned sum `a_i + b_i + cin_i`.
- R3: `blk_p_o` is 1 exactly when every bit position has differing inputs, that is when `a_i ^ b_i` is all ones.
- R4: `blk_g_o` is 1 exactly when `a_i + b_i` with no carry-in reaches 2^16, meaning a carry leaves bit 15 whatever `cin_i` is.
- R5: When `blk_p_o` is 1, `cout_o` equals `cin_i` and every bit of `sum_o` equals the inverse of `cin_i`.
- R6: When `blk_g_o` and `blk_p_o` are both 0, `cout_o` is 0 for either value of `cin_i`.
- R7: The carry entering group k (bit position 4k, for k = 1, 2, 3) equals bit 4k of the unsigned sum of the operands' low 4k bits and `cin_i`; at the ports it shows as `sum_o[4k] ^ a_i[4k] ^ b_i[4k]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | 16 | Sum bits |
| cout_o | output | 1 | Carry out of bit 15 |
| blk_g_o | output | 1 | Block generate: a carry leaves the block regardless of `cin_i` |
| blk_p_o | output | 1 | Block propagate: `cin_i` passes straight through to `cout_o` |

## Verification
The checks take the inputs to be fully driven with known 0/1 values, and they evaluate only after the combinational network has settled on a given input set. The bench changes operands one time per clock, just after the rising edge, and compares near the falling edge, so each comparison sees settled outputs. Stimulus covers fixed corner patterns: all zeros, all ones, full propagate with both carry-in values, a carry crossing each group boundary, a sign-bit carry. Random operands follow, part of them with `b_i` set to the inverse of `a_i` so that the block-propagate case comes up often.

// File: rtl/cla_pkg.sv
package cla_pkg;
  // Default partition: four groups of four bits.
  localparam int unsigned DEF_GRP_W = 4;
  localparam int unsigned DEF_GRP_N = 4;
endpackage

// File: rtl/cla_bit_pg.sv
module cla_bit_pg #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] gen_o,
  output logic [W-1:0] prp_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign gen_o[i] = x_i[i] & y_i[i];
    assign prp_o[i] = x_i[i] ^ y_i[i];
  end
endmodule

// File: rtl/cla_unit.sv
// Lookahead over N generate/propagate pairs. Every carry is formed as a
// flat sum of products of the pairs and the incoming carry.
module cla_unit #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] gen_i,
  input  logic [N-1:0] prp_i,
  input  logic         cin_i,
  output logic [N-1:0] cy_o,
  output logic         grp_g_o,
  output logic         grp_p_o
);
  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic acc;
      logic trm;
      trm = cin_i;
      for (int k = 0; k < i; k++) trm = trm & prp_i[k];
      acc = trm;
      for (int j = 0; j < i; j++) begin
        trm = gen_i[j];
        for (int k = j + 1; k < i; k++) trm = trm & prp_i[k];
        acc = acc | trm;
      end
      cy_o[i] = acc;
    end
  end

  always_comb begin
    logic acc;
    logic trm;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      trm = gen_i[j];
      for (int k = j + 1; k < N; k++) trm = trm & prp_i[k];
      acc = acc | trm;
    end
    grp_g_o = acc;
  end

  assign grp_p_o = &prp_i;
endmodule

// File: rtl/cla_group.sv
module cla_group #(
  parameter int unsigned GW = 4
) (
  input  logic [GW-1:0] x_i,
  input  logic [GW-1:0] y_i,
  input  logic          cin_i,
  output logic [GW-1:0] sum_o,
  output logic          grp_g_o,
  output logic          grp_p_o
);
  logic [GW-1:0] gen;
  logic [GW-1:0] prp;
  logic [GW-1:0] cy;

  cla_bit_pg #(.W(GW)) u_pg (
    .x_i   (x_i),
    .y_i   (y_i),
    .gen_o (gen),
    .prp_o (prp)
  );

  cla_unit #(.N(GW)) u_la (
    .gen_i   (gen),
    .prp_i   (prp),
    .cin_i   (cin_i),
    .cy_o    (cy),
    .grp_g_o (grp_g_o),
    .grp_p_o (grp_p_o)
  );

  assign sum_o = prp ^ cy;
endmodule

// File: rtl/cla_hier_adder.sv
module cla_hier_adder #(
  parameter int unsigned GRP_W = cla_pkg::DEF_GRP_W,
  parameter int unsigned GRP_N = cla_pkg::DEF_GRP_N,
  localparam int unsigned W    = GRP_W * GRP_N
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o,
  output logic         blk_g_o,
  output logic         blk_p_o
);
  logic [GRP_N-1:0] grp_g;
  logic [GRP_N-1:0] grp_p;
  logic [GRP_N-1:0] grp_cin;

  for (genvar k = 0; k < GRP_N; k++) begin : g_grp
    cla_group #(.GW(GRP_W)) u_grp (
      .x_i     (a_i[k*GRP_W +: GRP_W]),
      .y_i     (b_i[k*GRP_W +: GRP_W]),
      .cin_i   (grp_cin[k]),
      .sum_o   (sum_o[k*GRP_W +: GRP_W]),
      .grp_g_o (grp_g[k]),
      .grp_p_o (grp_p[k])
    );
  end

  // Second level: carries into every group straight from group terms.
  cla_unit #(.N(GRP_N)) u_top_la (
    .gen_i   (grp_g),
    .prp_i   (grp_p),
    .cin_i   (cin_i),
    .cy_o    (grp_cin),
    .grp_g_o (blk_g_o),
    .grp_p_o (blk_p_o)
  );

  assign cout_o = blk_g_o | (blk_p_o & cin_i);
endmodule

// File: rtl/cla_hier_adder_chk.sv
module cla_hier_adder_chk #(
  parameter int unsigned GRP_W = 4,
  parameter int unsigned GRP_N = 4,
  localparam int unsigned W    = GRP_W * GRP_N
) (
  input logic [W-1:0]     a_i,
  input logic [W-1:0]     b_i,
  input logic             cin_i,
  input logic [W-1:0]     sum_o,
  input logic             cout_o,
  input logic             blk_g_o,
  input logic             blk_p_o,
  input logic [GRP_N-1:0] grp_cin
);
  always_comb begin
    logic [W:0] full;
    logic [W:0] nocin;
    full  = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
    nocin = {1'b0, a_i} + {1'b0, b_i};
    if (!$isunknown({a_i, b_i, cin_i})) begin
      AST_SUM_VALUE: assert (sum_o == full[W-1:0]); // R1
      AST_CARRY_OUT: assert (cout_o == full[W]); // R2
      AST_BLK_GEN: assert (blk_g_o == nocin[W]); // R4
      AST_PROP_PASS: assert (!blk_p_o || (cout_o == cin_i && sum_o == {W{~cin_i}})); // R5
      AST_NO_GEN_NO_PROP: assert (blk_g_o || blk_p_o || !cout_o); // R6
      for (int k = 1; k < GRP_N; k++) begin
        logic [W:0] msk;
        logic [W:0] low;
        msk = ({{W{1'b0}}, 1'b1} << (k * GRP_W)) - 1'b1;
        low = ({1'b0, a_i} & msk) + ({1'b0, b_i} & msk) + {{W{1'b0}}, cin_i};
        AST_GRP_CARRY: assert (grp_cin[k] == low[k*GRP_W]); // R7
      end
    end
  end
endmodule

bind cla_hier_adder cla_hier_adder_chk #(.GRP_W(GRP_W), .GRP_N(GRP_N)) u_chk (
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .blk_g_o (blk_g_o),
  .blk_p_o (blk_p_o),
  .grp_cin (grp_cin)
);

// File: tb/sim_cla_hier_adder.sv
module sim_cla_hier_adder;
  logic        clk;
  logic        rst_n;
  logic [15:0] a;
  logic [15:0] b;
  logic        cin;
  logic [15:0] sum;
  logic        cout;
  logic        bg;
  logic        bp;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 0;

  cla_hier_adder u0 (
    .a_i     (a),
    .b_i     (b),
    .cin_i   (cin),
    .sum_o   (sum),
    .cout_o  (cout),
    .blk_g_o (bg),
    .blk_p_o (bp)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%0d act=%0h exp=%0h", req, a, b, cin, act, exp);
    end
  endtask

  // Reference: plain integer addition, evaluated per vector.
  task automatic run_vec(input logic [15:0] va, input logic [15:0] vb, input logic vc);
    int unsigned s;
    int unsigned s0;
    @(posedge clk);
    #1;
    a = va; b = vb; cin = vc;
    @(negedge clk);
    s  = int'(va) + int'(vb) + int'(vc);
    s0 = int'(va) + int'(vb);
    chk("R1", 32'(sum), s & 32'hFFFF);
    chk("R2", 32'(cout), (s >> 16) & 1);
    chk("R3", 32'(bp), 32'((va ^ vb) == 16'hFFFF));
    chk("R4", 32'(bg), (s0 >> 16) & 1);
    if ((va ^ vb) == 16'hFFFF) begin
      chk("R5", 32'({cout, sum}), 32'({vc, {16{~vc}}}));
    end
    if ((s0 >> 16) == 0 && (va ^ vb) != 16'hFFFF) begin
      chk("R6", 32'(cout), 32'd0);
    end
    for (int k = 1; k < 4; k++) begin
      int unsigned m;
      int unsigned lo;
      m  = (32'd1 << (4 * k)) - 1;
      lo = (int'(va) & m) + (int'(vb) & m) + int'(vc);
      chk("R7", 32'(sum[4*k] ^ va[4*k] ^ vb[4*k]), (lo >> (4 * k)) & 1);
    end
  endtask

  initial begin
    logic [15:0] ca[$];
    logic [15:0] cb[$];
    logic        cc[$];
    rst_n = 1'b0;
    a = '0; b = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", 32'(sum), 32'd0);
    chk("R2", 32'(cout), 32'd0);
    chk("R4", 32'(bg), 32'd0);
    chk("R3", 32'(bp), 32'd0);
    rst_n = 1'b1;
    ca = '{16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'h8000,
           16'hAAAA, 16'hAAAA, 16'h000F, 16'h00FF, 16'h0FFF, 16'h7FFF, 16'h0F0F};
    cb = '{16'h0000, 16'h0000, 16'h0000, 16'h0001, 16'hFFFF, 16'hFFFF, 16'h8000,
           16'h5555, 16'h5555, 16'h0001, 16'h0001, 16'h0001, 16'h0001, 16'h00F1};
    cc = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
           1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    foreach (ca[i]) run_vec(ca[i], cb[i], cc[i]);
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] ra;
      logic [15:0] rb;
      ra = 16'($urandom);
      rb = (n % 5 == 0) ? ~ra : 16'($urandom);
      run_vec(ra, rb, 1'($urandom));
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule